// File: doc/BRIEF.md
# Single-Bus Multicycle Processor Core

A 32-bit processor core in which every register transfer travels over one shared internal bus, one transfer per clock step. The datapath holds a 32-entry register file, an operand latch feeding the left side of the ALU, a result register behind the ALU, a program counter, an instruction register, a memory address register and a memory data register. A hardwired controller counts time steps and decodes the current step and opcode into gate signals (which source drives the bus) and strobe signals (which registers capture it).

Each instruction starts with a three-step fetch and then runs its own execute steps: register add, add-immediate, load, store and conditional branch. Any other opcode finishes right after fetch and changes nothing. The core talks to a simple memory through an address, a write-data word, a read-data word, read and write request levels and a done strobe. A request is held until done arrives, and the controller stays in that step for as long as it waits.

Top module: `onebus_core`

## Requirements
- R1: A synchronous active-low reset clears the step counter, the program counter and all 32 registers. The first read after reset is issued at address 0.
- R2: Fetch puts PC on the address lines, reads the word at PC into the instruction register and advances PC by 4. With a memory that raises done L+1 cycles after a request begins, fetch requests of two consecutive add or add-immediate instructions start exactly L+7 cycles apart. End returns the step counter to step 0.
- R3: While a read or write request is waiting for done, the request level, the address and the write data stay unchanged. Read and write are never requested together, and each store causes exactly one memory write.
- R4: add (opcode 12 in bits 31..27) writes R[ra] = R[rb] + R[rc] modulo 2^32. ra is bits 26..22, rb is bits 21..17 and rc is bits 16..12.
- R5: add-immediate (opcode 13) writes R[ra] = R[rb] + k, where k is bits 16..0 sign-extended from bit 16.
- R6: load (opcode 1) and store (opcode 3) use the address base + k, where base is 0 when rb is 0 and R[rb] otherwise. Load writes the memory word into R[ra], and store writes R[ra] to memory.
- R7: branch (opcode 8) loads PC with R[rb] when the condition in bits 2..0, tested on R[rc], holds. The codes are: 0 never, 1 always, 2 equal to zero, 3 not zero, 4 bit 31 clear, 5 bit 31 set, 6 and 7 never. Otherwise execution falls through to PC+4.
- R8: Every other opcode changes no register and no memory word. Its fetch request and the next fetch request start L+5 cycles apart.
- R9: No more than one source drives the internal bus in any step. When add names register 0 as an operand, it uses the stored contents of register 0, not zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Memory byte address, taken from the address register |
| mem_wdata | output | 32 | Store data, taken from the data register |
| mem_rdata | input | 32 | Word read from memory |
| mem_rd | output | 1 | Read request, held until done |
| mem_wr | output | 1 | Write request, held until done |
| mem_done | input | 1 | One-cycle completion strobe from memory |

## Verification
In a wait step the arrival of done can fall in the same cycle as other strobes. During fetch, PC is strobed from the result register while the read is still pending. In the last store step, completion of the write coincides with End returning the counter to step 0. The bench runs every program with memory latencies from 0 to 3 cycles so that done lands at each possible distance from these strobes. It then judges the result through the next fetch address, the spacing between fetch requests, the stored words and the count of memory writes.

// File: rtl/onebus_pkg.sv
// Shared constants and types for the single-bus core.
// Assumes a 32-bit word and a fixed instruction field layout.
package onebus_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RSEL_W = $clog2(NREG);
    localparam int STEP_W = 3;

    localparam logic [4:0] OP_LD   = 5'd1;
    localparam logic [4:0] OP_ST   = 5'd3;
    localparam logic [4:0] OP_BR   = 5'd8;
    localparam logic [4:0] OP_ADD  = 5'd12;
    localparam logic [4:0] OP_ADDI = 5'd13;

    typedef enum logic [2:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_NOT, ALU_PASSB, ALU_INC4
    } alu_op_e;

    typedef enum logic [1:0] {SEL_NONE, SEL_RA, SEL_RB, SEL_RC} rsel_e;

    // Gate (bus source) and strobe (register capture) controls for one step
    typedef struct packed {
        logic    pc_out;
        logic    md_out;
        logic    c_out;
        logic    r_out;
        logic    ba_out;
        logic    c2_out;
        logic    pc_in;
        logic    pc_in_if;
        logic    ir_in;
        logic    ma_in;
        logic    md_in;
        logic    a_in;
        logic    c_in;
        logic    r_in;
        logic    con_in;
        logic    rd;
        logic    wr;
        logic    stall;
        logic    fin;
        rsel_e   rsel;
        alu_op_e alu;
    } ctl_t;
endpackage

// File: rtl/onebus_regfile.sv
// Register file: NREG words, one select shared by read and write.
// Assumes that only one register transfer per step uses the select.
// base_data returns zero when register 0 is selected (base-address path).
module onebus_regfile #(
    parameter int NREG = 32,
    parameter int XLEN = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   sel,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rd_data,
    output logic [XLEN-1:0] base_data
);
    logic [XLEN-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [XLEN-1:0] q;
        // Capture the bus into this register when it is selected and strobed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && sel == AW'(g))
                q <= wdata;
        end
        assign regs[g] = q;
    end

    assign rd_data   = regs[sel];
    assign base_data = (sel == '0) ? '0 : regs[sel];
endmodule

// File: rtl/onebus_alu.sv
// ALU: left operand from the A latch, right operand from the bus.
// Purely combinational; the result is captured by the C register.
module onebus_alu
    import onebus_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);
    // Select the function on the two operands
    always_comb begin
        case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_AND:  y = a & b;
            ALU_NOT:  y = ~b;
            ALU_INC4: y = b + W'(4);
            default:  y = b;
        endcase
    end
endmodule

// File: rtl/onebus_ctrl.sv
// Hardwired controller: a step counter plus a decoder from (step, opcode)
// to gate and strobe controls. A step marked stall holds until mem_done;
// a step marked fin returns to step 0 once it may advance.
module onebus_ctrl
    import onebus_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        opcode,
    input  logic              mem_done,
    output ctl_t              ctl,
    output logic [STEP_W-1:0] step
);
    logic hold;

    // Decode the current step and opcode into control signals
    always_comb begin
        ctl = '0;
        case (step)
            3'd0: begin ctl.pc_out = 1'b1; ctl.ma_in = 1'b1; ctl.alu = ALU_INC4; ctl.c_in = 1'b1; end
            3'd1: begin ctl.c_out = 1'b1; ctl.pc_in = 1'b1; ctl.rd = 1'b1; ctl.stall = 1'b1; end
            3'd2: begin ctl.md_out = 1'b1; ctl.ir_in = 1'b1; end
            default: begin
                case (opcode)
                    OP_ADD, OP_ADDI: begin
                        case (step)
                            3'd3: begin ctl.rsel = SEL_RB; ctl.r_out = 1'b1; ctl.a_in = 1'b1; end
                            3'd4: begin
                                if (opcode == OP_ADD) begin ctl.rsel = SEL_RC; ctl.r_out = 1'b1; end
                                else ctl.c2_out = 1'b1;
                                ctl.alu = ALU_ADD; ctl.c_in = 1'b1;
                            end
                            default: begin ctl.c_out = 1'b1; ctl.rsel = SEL_RA; ctl.r_in = 1'b1; ctl.fin = 1'b1; end
                        endcase
                    end
                    OP_LD, OP_ST: begin
                        case (step)
                            3'd3: begin ctl.rsel = SEL_RB; ctl.ba_out = 1'b1; ctl.a_in = 1'b1; end
                            3'd4: begin ctl.c2_out = 1'b1; ctl.alu = ALU_ADD; ctl.c_in = 1'b1; end
                            3'd5: begin ctl.c_out = 1'b1; ctl.ma_in = 1'b1; end
                            3'd6: begin
                                if (opcode == OP_LD) begin ctl.rd = 1'b1; ctl.stall = 1'b1; end
                                else begin ctl.rsel = SEL_RA; ctl.r_out = 1'b1; ctl.md_in = 1'b1; end
                            end
                            default: begin
                                if (opcode == OP_LD) begin ctl.md_out = 1'b1; ctl.rsel = SEL_RA; ctl.r_in = 1'b1; end
                                else begin ctl.wr = 1'b1; ctl.stall = 1'b1; end
                                ctl.fin = 1'b1;
                            end
                        endcase
                    end
                    OP_BR: begin
                        if (step == 3'd3) begin ctl.rsel = SEL_RC; ctl.r_out = 1'b1; ctl.con_in = 1'b1; end
                        else begin ctl.rsel = SEL_RB; ctl.r_out = 1'b1; ctl.pc_in_if = 1'b1; ctl.fin = 1'b1; end
                    end
                    default: ctl.fin = 1'b1;
                endcase
            end
        endcase
    end

    assign hold = ctl.stall & ~mem_done;

    // Advance, hold in a wait step, or return to step 0 at End
    always_ff @(posedge clk) begin
        if (!rst_n)
            step <= '0;
        else if (!hold)
            step <= ctl.fin ? '0 : step + STEP_W'(1);
    end
endmodule

// File: rtl/onebus_core.sv
// Single-bus multicycle core: PC, IR, MA, MD, A, C, CON and the register
// file share one bus driven by exactly one gated source per step.
// Assumes a memory that holds done low until a held request completes.
module onebus_core
    import onebus_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            mem_rd,
    output logic            mem_wr,
    input  logic            mem_done
);
    localparam int IMM_W = 17;

    ctl_t              ctl;
    logic [STEP_W-1:0] step;
    logic [XLEN-1:0]   pc_q, ir_q, ma_q, md_q, a_q, c_q;
    logic [XLEN-1:0]   bus, alu_y, r_data, ba_data, c2_ext;
    logic [RSEL_W-1:0] rsel;
    logic [5:0]        bus_gates;
    logic              con_q, cond;

    onebus_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .opcode(ir_q[31:27]),
        .mem_done(mem_done), .ctl(ctl), .step(step)
    );

    onebus_regfile #(.NREG(NREG), .XLEN(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n), .sel(rsel), .wr_en(ctl.r_in),
        .wdata(bus), .rd_data(r_data), .base_data(ba_data)
    );

    onebus_alu #(.W(XLEN)) u_alu (.a(a_q), .b(bus), .op(ctl.alu), .y(alu_y));

    assign c2_ext    = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
    assign bus_gates = {ctl.pc_out, ctl.md_out, ctl.c_out, ctl.r_out, ctl.ba_out, ctl.c2_out};

    // Map the register-select gate onto an instruction field
    always_comb begin
        case (ctl.rsel)
            SEL_RA:  rsel = ir_q[26:22];
            SEL_RB:  rsel = ir_q[21:17];
            SEL_RC:  rsel = ir_q[16:12];
            default: rsel = '0;
        endcase
    end

    // Bus multiplexer: the gated source drives the bus, otherwise zero
    always_comb begin
        if (bus_gates[5])      bus = pc_q;
        else if (bus_gates[4]) bus = md_q;
        else if (bus_gates[3]) bus = c_q;
        else if (bus_gates[2]) bus = r_data;
        else if (bus_gates[1]) bus = ba_data;
        else if (bus_gates[0]) bus = c2_ext;
        else                   bus = '0;
    end

    // Branch condition evaluated on the bus value
    always_comb begin
        case (ir_q[2:0])
            3'd1:    cond = 1'b1;
            3'd2:    cond = (bus == '0);
            3'd3:    cond = (bus != '0);
            3'd4:    cond = ~bus[XLEN-1];
            3'd5:    cond = bus[XLEN-1];
            default: cond = 1'b0;
        endcase
    end

    // Strobe the datapath registers from the bus, the ALU or memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0; ir_q <= '0; ma_q <= '0; md_q <= '0;
            a_q  <= '0; c_q  <= '0; con_q <= 1'b0;
        end else begin
            if (ctl.pc_in || (ctl.pc_in_if && con_q)) pc_q <= bus;
            if (ctl.ir_in)  ir_q  <= bus;
            if (ctl.ma_in)  ma_q  <= bus;
            if (ctl.a_in)   a_q   <= bus;
            if (ctl.c_in)   c_q   <= alu_y;
            if (ctl.con_in) con_q <= cond;
            if (ctl.md_in)  md_q  <= bus;
            else if (ctl.rd && mem_done) md_q <= mem_rdata;
        end
    end

    assign mem_addr  = ma_q;
    assign mem_wdata = md_q;
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
endmodule

// File: rtl/onebus_chk.sv
// Property checker for onebus_core, attached by bind.
module onebus_chk
    import onebus_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   mem_addr,
    input logic [XLEN-1:0]   mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_done,
    input logic [5:0]        bus_gates,
    input logic [STEP_W-1:0] step,
    input ctl_t              ctl
);
    // R1
    reset_step_chk: assert property (@(posedge clk) !rst_n |=> step == '0);

    // R2
    end_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.fin && !(ctl.stall && !mem_done) |=> step == '0);

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_done |=> mem_rd && $stable(mem_addr));

    // R3
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr && !mem_done |=> mem_wr && $stable(mem_addr) && $stable(mem_wdata));

    // R3
    stall_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.stall && !mem_done |=> $stable(step));

    // R3
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R9
    one_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_gates));
endmodule

bind onebus_core onebus_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_done(mem_done),
    .bus_gates(bus_gates), .step(step), .ctl(ctl)
);

// File: tb/test_onebus_core.sv
// Bench: small programs swept over operands, condition codes, opcodes and
// memory latencies; results read back from the bench memory model.
module test_onebus_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_rd, mem_wr;
    logic        mem_done = 1'b0;
    logic [31:0] mem [256];
    int          lat = 0, cnt = 0, wcount = 0;
    int          total = 0, bad = 0, cyc = 0, nrise = 0, pidx = 0;
    int          rise_t [8];
    logic [31:0] rise_a [8];
    logic        prev_rd = 1'b0;

    always #5 clk = ~clk;

    onebus_core i_onebus_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_done(mem_done)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    // Memory model: done rises lat+1 cycles after a request begins
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_done <= 1'b0; cnt <= 0; wcount <= 0;
        end else if (mem_done) begin
            mem_done <= 1'b0; cnt <= 0;
            if (mem_wr) begin mem[mem_addr[9:2]] = mem_wdata; wcount <= wcount + 1; end
        end else if (mem_rd || mem_wr) begin
            if (cnt == lat) mem_done <= 1'b1;
            else cnt <= cnt + 1;
        end
    end

    // Record start cycle and address of each read request
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) nrise = 0;
        else if (mem_rd && !prev_rd && nrise < 8) begin
            rise_t[nrise] = cyc; rise_a[nrise] = mem_addr; nrise++;
        end
        prev_rd = mem_rd;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_i(input logic [4:0] op, input logic [4:0] ra,
                                        input logic [4:0] rb, input logic [16:0] k);
        return {op, ra, rb, k};
    endfunction
    function automatic logic [31:0] f_addi(input logic [4:0] ra, rb, input logic [16:0] k);
        return f_i(5'd13, ra, rb, k);
    endfunction
    function automatic logic [31:0] f_add(input logic [4:0] ra, rb, rc);
        return f_i(5'd12, ra, rb, {rc, 12'd0});
    endfunction
    function automatic logic [31:0] f_br(input logic [4:0] rb, rc, input logic [2:0] code);
        return f_i(5'd8, 5'd0, rb, {rc, 9'd0, code});
    endfunction
    function automatic logic [31:0] sx(input logic [16:0] k);
        return {{15{k[16]}}, k};
    endfunction

    task automatic put(input logic [31:0] w);
        mem[pidx] = w; pidx++;
    endtask

    // Hold reset, clear memory, plant the halt loop and set r31 to it
    task automatic start_prog(input int l);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        lat = l; pidx = 0;
        mem[124] = f_br(5'd31, 5'd0, 3'd1);
        put(f_addi(5'd31, 5'd0, 17'h001F0));
    endtask

    task automatic go(input int n);
        @(negedge clk); rst_n = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [16:0] imms [5];
        logic [16:0] bvals [3];
        logic [31:0] vals [2];
        imms[0] = 17'h0FFFF; imms[1] = 17'h10000; imms[2] = 17'h1FFFF;
        imms[3] = 17'h00001; imms[4] = 17'h0ABCD;
        bvals[0] = 17'h00000; bvals[1] = 17'h00005; bvals[2] = 17'h1FFFF;
        vals[0] = 32'h1234_5678; vals[1] = 32'hFEDC_BA98;

        // add / add-immediate sweep over operand pairs and latencies
        for (int i = 0; i < 5; i++) begin
            for (int j = 0; j < 5; j++) begin
                start_prog((i + j) % 4);
                put(f_addi(5'd1, 5'd0, imms[i]));
                put(f_addi(5'd2, 5'd0, imms[j]));
                put(f_add(5'd3, 5'd1, 5'd2));
                put(f_i(5'd3, 5'd3, 5'd0, 17'h00200));
                put(f_i(5'd3, 5'd1, 5'd0, 17'h00204));
                put(f_br(5'd31, 5'd0, 3'd1));
                go(200);
                check("R4 add sum", mem[128], sx(imms[i]) + sx(imms[j]));
                check("R5 addi sign extension", mem[129], sx(imms[i]));
                check("R2 fetch spacing", 32'(rise_t[1] - rise_t[0]), 32'(lat + 7));
                check("R2 second fetch address", rise_a[1], 32'd4);
                if (i == 0 && j == 0) check("R1 first fetch address", rise_a[0], 32'd0);
            end
        end

        // R1: registers cleared by reset (r1, r2 were set above)
        start_prog(1);
        mem[128] = 32'hDEAD_BEEF;
        put(f_i(5'd3, 5'd1, 5'd0, 17'h00200));
        put(f_i(5'd3, 5'd2, 5'd0, 17'h00204));
        put(f_br(5'd31, 5'd0, 3'd1));
        go(150);
        check("R1 r1 cleared", mem[128], 32'd0);
        check("R1 r2 cleared", mem[129], 32'd0);

        // load / store, base register and register-0 base
        for (int l = 0; l < 4; l++) begin
            for (int v = 0; v < 2; v++) begin
                start_prog(l);
                mem[192] = vals[v];
                put(f_addi(5'd4, 5'd0, 17'h002F0));
                put(f_i(5'd1, 5'd6, 5'd4, 17'h00010));
                put(f_i(5'd3, 5'd6, 5'd4, 17'h00040));
                put(f_addi(5'd7, 5'd0, 17'h00380));
                put(f_i(5'd3, 5'd6, 5'd7, 17'h1FFF0));
                put(f_addi(5'd0, 5'd0, 17'h00100));
                put(f_i(5'd1, 5'd8, 5'd0, 17'h00300));
                put(f_add(5'd9, 5'd0, 5'd0));
                put(f_i(5'd3, 5'd9, 5'd0, 17'h00340));
                put(f_i(5'd3, 5'd8, 5'd0, 17'h00344));
                put(f_br(5'd31, 5'd0, 3'd1));
                go(400);
                check("R6 load then store positive disp", mem[204], vals[v]);
                check("R6 store negative disp", mem[220], vals[v]);
                check("R9 add reads stored r0", mem[208], 32'h0000_0200);
                check("R6 load with rb=0 base zero", mem[209], vals[v]);
                check("R3 one write per store", 32'(wcount), 32'd4);
            end
        end

        // branch: every condition code against zero, positive, negative
        for (int c = 0; c < 8; c++) begin
            for (int b = 0; b < 3; b++) begin
                logic taken;
                logic [31:0] bv;
                bv = sx(bvals[b]);
                case (c)
                    1: taken = 1'b1;
                    2: taken = (bv == 32'd0);
                    3: taken = (bv != 32'd0);
                    4: taken = ~bv[31];
                    5: taken = bv[31];
                    default: taken = 1'b0;
                endcase
                start_prog((c + b) % 4);
                put(f_addi(5'd1, 5'd0, bvals[b]));
                put(f_addi(5'd2, 5'd0, 17'h00040));
                put(f_br(5'd2, 5'd1, 3'(c)));
                put(f_addi(5'd4, 5'd0, 17'h00011));
                put(f_i(5'd3, 5'd4, 5'd0, 17'h00200));
                put(f_br(5'd31, 5'd0, 3'd1));
                pidx = 16;
                put(f_addi(5'd4, 5'd0, 17'h00022));
                put(f_i(5'd3, 5'd4, 5'd0, 17'h00200));
                put(f_br(5'd31, 5'd0, 3'd1));
                go(200);
                check("R7 branch outcome", mem[128], taken ? 32'h22 : 32'h11);
            end
        end

        // R8: every unimplemented opcode is a short no-op
        for (int op = 0; op < 32; op++) begin
            if (op == 1 || op == 3 || op == 8 || op == 12 || op == 13) continue;
            start_prog(op % 4);
            put(f_addi(5'd1, 5'd0, 17'h00007));
            put(f_i(5'(op), 5'd1, 5'd1, 17'h00005));
            put(f_i(5'd3, 5'd1, 5'd0, 17'h00200));
            put(f_br(5'd31, 5'd0, 3'd1));
            go(150);
            check("R8 no-op leaves register", mem[128], 32'd7);
            check("R8 no-op fetch spacing", 32'(rise_t[3] - rise_t[2]), 32'(lat + 5));
            check("R8 no-op falls through", rise_a[3], 32'd12);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule